// File: doc/BRIEF.md
# Multi-phase framed serial receiver

This block takes a synchronous serial bit stream together with its bit clock and a frame-sync pulse, and turns each received element into a 32-bit parallel word with a one-cycle valid strobe. Everything is sampled and processed in the system clock domain. The serial clock and frame sync are registered, and edges of the internal serial clock are detected from them. The serial clock must therefore run well below the system clock: each serial clock level has to be held for at least two system clock cycles.

A frame has either one or two phases. Each phase has its own element width and element count. A programmable delay of 0 to 2 bit periods separates the frame sync from the first data bit. A frame sync that arrives mid-frame either restarts reception or is ignored. Each word leaves right-justified with zero fill, right-justified with sign extension, or left-justified. The consumer acknowledges each word with a read strobe. An element that completes before the previous word was read sets a sticky overrun flag.

The controller has four states. ST_IDLE waits for a frame sync. ST_DELAY counts the skipped bit periods. ST_PH1 and ST_PH2 shift in the bits of phase 1 and phase 2. The transitions are these:
- T_START leaves ST_IDLE on a frame sync, going to ST_DELAY, or to ST_PH1 when the delay is zero.
- T_RESTART re-enters ST_DELAY or ST_PH1 from any busy state.
- T_DELAY_DONE goes from ST_DELAY to ST_PH1.
- T_PH_SWITCH goes from ST_PH1 to ST_PH2.
- T_FRAME_END returns to ST_IDLE after the last element of the final phase.

Top module: `framed_rx`

## Requirements
- R1: The internal serial clock is `sclk_i` XOR `cfg_clk_inv`, and each data bit is captured on a rising edge of this internal clock.
- R2: The frame-sync level is `fs_i` XOR `cfg_fs_inv`, sampled on falling edges of the internal clock. A frame-sync event is a falling-edge sample that is active when the previous falling-edge sample was inactive.
- R3: In ST_IDLE a frame-sync event always starts a frame in phase 1, and no word is delivered while idle.
- R4: Element widths are coded as 0=8, 1=12, 2=16, 3=20, 4=24 and 5, 6 or 7=32 bits. Bits arrive most-significant first.
- R5: A phase holds its count field plus one elements, from 1 to 128.
- R6: With `cfg_dual`=1, phase 2 follows phase 1 using `cfg_len2` and `cfg_cnt2`. With `cfg_dual`=0, the frame ends after phase 1.
- R7: With delay code D (where 3 acts as 2), the first data bit is taken on rising edge number D+1 after the falling edge that saw the frame-sync event.
- R8: With `cfg_fs_ignore`=0, a frame-sync event inside a frame restarts it in phase 1 and drops the partial element.
- R9: With `cfg_fs_ignore`=1, a frame-sync event inside a frame has no effect on reception.
- R10: Justify code 0 gives right-justified zero fill. Code 1 gives right-justified sign extension from the element's top bit. Codes 2 and 3 give left-justified with zeros below.
- R11: Each completed element raises `valid_o` for exactly one system clock with the word on `word_o`.
- R12: `overrun_o` is set, and stays set until reset, when an element completes while the previous word is still unread. A `rd_i` high in the completion cycle counts as having read it.
- R13: After reset `word_o` is 0, and `valid_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial bit clock |
| fs_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial data |
| cfg_clk_inv | input | 1 | Invert serial clock |
| cfg_fs_inv | input | 1 | Invert frame sync |
| cfg_dual | input | 1 | Two-phase frames |
| cfg_len1 | input | 3 | Phase 1 element width code |
| cfg_len2 | input | 3 | Phase 2 element width code |
| cfg_cnt1 | input | CNT_W | Phase 1 elements minus one |
| cfg_cnt2 | input | CNT_W | Phase 2 elements minus one |
| cfg_delay | input | 2 | Frame-sync to data delay code |
| cfg_fs_ignore | input | 1 | Ignore frame sync mid-frame |
| cfg_just | input | 2 | Justification code |
| rd_i | input | 1 | Word read acknowledge |
| word_o | output | 32 | Received word |
| valid_o | output | 1 | Word valid strobe |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Two events can land in the same system cycle: the completion of an element and the consumer's read acknowledge. The bench provokes this by holding `rd_i` high through whole frames, so every completion meets a read in its own cycle. It then expects `overrun_o` to stay low. A second run keeps `rd_i` low, and the flag must appear on the second element only. A behavioural model runs at bit-slot level, turning the same driven stream into expected words. Every system clock, any valid strobe is compared with the head of that queue, and restart and ignore cases decide which partial elements exist.

// File: rtl/framed_rx_pkg.sv
package framed_rx_pkg;

    localparam int WORD_W    = 32;
    localparam int BIT_CNT_W = $clog2(WORD_W);

    typedef logic [BIT_CNT_W:0] wlen_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_PH1,
        ST_PH2
    } rx_state_e;

    localparam logic [1:0] JUST_ZERO = 2'd0;
    localparam logic [1:0] JUST_SIGN = 2'd1;

    function automatic wlen_t len_decode(input logic [2:0] code);
        case (code)
            3'd0:    return wlen_t'(8);
            3'd1:    return wlen_t'(12);
            3'd2:    return wlen_t'(16);
            3'd3:    return wlen_t'(20);
            3'd4:    return wlen_t'(24);
            default: return wlen_t'(32);
        endcase
    endfunction

endpackage

// File: rtl/framed_rx_edge.sv
module framed_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fs_i,
    input  logic sd_i,
    input  logic cfg_clk_inv,
    input  logic cfg_fs_inv,
    output logic rise,
    output logic fall,
    output logic fs_lvl,
    output logic sd_bit
);
    logic c_now, c_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_now  <= 1'b0;
            c_old  <= 1'b0;
            fs_lvl <= 1'b0;
            sd_bit <= 1'b0;
        end else begin
            c_now  <= sclk_i ^ cfg_clk_inv;
            c_old  <= c_now;
            fs_lvl <= fs_i ^ cfg_fs_inv;
            sd_bit <= sd_i;
        end
    end

    assign rise = c_now & ~c_old;
    assign fall = ~c_now & c_old;

endmodule

// File: rtl/framed_rx_fsm.sv
module framed_rx_fsm
    import framed_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 fs_lvl,
    input  logic                 sd_bit,
    input  logic                 cfg_dual,
    input  logic [2:0]           cfg_len1,
    input  logic [2:0]           cfg_len2,
    input  logic [CNT_W-1:0]     cfg_cnt1,
    input  logic [CNT_W-1:0]     cfg_cnt2,
    input  logic [1:0]           cfg_delay,
    input  logic                 cfg_fs_ignore,
    output logic                 elem_done,
    output logic [WORD_W-1:0]    elem_raw,
    output wlen_t                elem_w
);
    rx_state_e              state, state_n;
    logic [1:0]             dcnt;
    logic [BIT_CNT_W-1:0]   bcnt;
    logic [CNT_W-1:0]       ecnt;
    logic [WORD_W-1:0]      shreg;
    logic                   fs_prev;

    wlen_t                  cur_w;
    logic [CNT_W-1:0]       cur_n;
    logic [1:0]             dly_eff;
    logic                   fs_event, take, in_phase, last_bit, last_elem;

    always_comb begin
        cur_w     = (state == ST_PH2) ? len_decode(cfg_len2) : len_decode(cfg_len1);
        cur_n     = (state == ST_PH2) ? cfg_cnt2 : cfg_cnt1;
        dly_eff   = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
        fs_event  = fall & fs_lvl & ~fs_prev;
        take      = fs_event & ((state == ST_IDLE) | ~cfg_fs_ignore);
        in_phase  = (state == ST_PH1) || (state == ST_PH2);
        last_bit  = ({1'b0, bcnt} == (cur_w - wlen_t'(1)));
        last_elem = (ecnt == cur_n);
    end

    // next-state logic: T_START / T_RESTART on take, the others on a data edge
    always_comb begin
        state_n = state;
        if (take) begin
            state_n = (dly_eff == 2'd0) ? ST_PH1 : ST_DELAY;
        end else if (rise) begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_DELAY: if (dcnt == 2'd1) state_n = ST_PH1;
                ST_PH1:   if (last_bit && last_elem) state_n = cfg_dual ? ST_PH2 : ST_IDLE;
                ST_PH2:   if (last_bit && last_elem) state_n = ST_IDLE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt      <= '0;
            bcnt      <= '0;
            ecnt      <= '0;
            shreg     <= '0;
            fs_prev   <= 1'b0;
            elem_done <= 1'b0;
            elem_raw  <= '0;
            elem_w    <= '0;
        end else begin
            elem_done <= 1'b0;
            if (fall) fs_prev <= fs_lvl;
            if (take) begin
                dcnt  <= dly_eff;
                bcnt  <= '0;
                ecnt  <= '0;
                shreg <= '0;
            end else if (rise) begin
                if (state == ST_DELAY) begin
                    dcnt <= dcnt - 2'd1;
                end else if (in_phase) begin
                    shreg <= {shreg[WORD_W-2:0], sd_bit};
                    if (last_bit) begin
                        bcnt      <= '0;
                        elem_done <= 1'b1;
                        elem_raw  <= {shreg[WORD_W-2:0], sd_bit};
                        elem_w    <= cur_w;
                        ecnt      <= last_elem ? '0 : ecnt + 1'b1;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end
        end
    end

    p_bitcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH1 || state == ST_PH2) |-> ({1'b0, bcnt} < cur_w));

    p_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fs_event) |=> (state != ST_IDLE && ecnt == '0 && bcnt == '0));

    p_delay_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (dcnt == 2'd1 || dcnt == 2'd2));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fs_ignore && state != ST_IDLE && fs_event) |=>
        ((state == ST_PH1 || state == ST_DELAY) && bcnt == '0 && ecnt == '0));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fs_ignore && state != ST_IDLE && fs_event) |=>
        (state == $past(state) && bcnt == $past(bcnt) && ecnt == $past(ecnt)));

endmodule

// File: rtl/framed_rx_pack.sv
module framed_rx_pack
    import framed_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elem_done,
    input  logic [WORD_W-1:0] elem_raw,
    input  wlen_t             elem_w,
    input  logic [1:0]        cfg_just,
    input  logic              rd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              overrun_o
);
    logic [WORD_W-1:0]    keep_mask, right_w, left_w, shaped;
    logic [BIT_CNT_W-1:0] msb_idx, lsh;
    logic                 sign_bit, full_q;

    always_comb begin
        msb_idx   = BIT_CNT_W'(elem_w - wlen_t'(1));
        lsh       = BIT_CNT_W'(wlen_t'(WORD_W) - elem_w);
        keep_mask = (elem_w >= wlen_t'(WORD_W)) ? '1
                                                : ((WORD_W'(1) << elem_w) - WORD_W'(1));
        sign_bit  = elem_raw[msb_idx];
        right_w   = (elem_raw & keep_mask)
                  | ((cfg_just == JUST_SIGN && sign_bit) ? ~keep_mask : '0);
        left_w    = elem_raw << lsh;
        shaped    = cfg_just[1] ? left_w : right_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o    <= '0;
            valid_o   <= 1'b0;
            overrun_o <= 1'b0;
            full_q    <= 1'b0;
        end else begin
            valid_o <= elem_done;
            if (elem_done) word_o <= shaped;
            full_q <= elem_done | (full_q & ~rd_i);
            if (elem_done && full_q && !rd_i) overrun_o <= 1'b1;
        end
    end

    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_overrun_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_overrun_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(elem_done && full_q && !rd_i));

endmodule

// File: rtl/framed_rx.sv
module framed_rx
    import framed_rx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             fs_i,
    input  logic             sd_i,
    input  logic             cfg_clk_inv,
    input  logic             cfg_fs_inv,
    input  logic             cfg_dual,
    input  logic [2:0]       cfg_len1,
    input  logic [2:0]       cfg_len2,
    input  logic [CNT_W-1:0] cfg_cnt1,
    input  logic [CNT_W-1:0] cfg_cnt2,
    input  logic [1:0]       cfg_delay,
    input  logic             cfg_fs_ignore,
    input  logic [1:0]       cfg_just,
    input  logic             rd_i,
    output logic [31:0]      word_o,
    output logic             valid_o,
    output logic             overrun_o
);
    logic              rise, fall, fs_lvl, sd_bit, elem_done;
    logic [WORD_W-1:0] elem_raw;
    wlen_t             elem_w;

    framed_rx_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .fs_i        (fs_i),
        .sd_i        (sd_i),
        .cfg_clk_inv (cfg_clk_inv),
        .cfg_fs_inv  (cfg_fs_inv),
        .rise        (rise),
        .fall        (fall),
        .fs_lvl      (fs_lvl),
        .sd_bit      (sd_bit)
    );

    framed_rx_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise          (rise),
        .fall          (fall),
        .fs_lvl        (fs_lvl),
        .sd_bit        (sd_bit),
        .cfg_dual      (cfg_dual),
        .cfg_len1      (cfg_len1),
        .cfg_len2      (cfg_len2),
        .cfg_cnt1      (cfg_cnt1),
        .cfg_cnt2      (cfg_cnt2),
        .cfg_delay     (cfg_delay),
        .cfg_fs_ignore (cfg_fs_ignore),
        .elem_done     (elem_done),
        .elem_raw      (elem_raw),
        .elem_w        (elem_w)
    );

    framed_rx_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .elem_done (elem_done),
        .elem_raw  (elem_raw),
        .elem_w    (elem_w),
        .cfg_just  (cfg_just),
        .rd_i      (rd_i),
        .word_o    (word_o),
        .valid_o   (valid_o),
        .overrun_o (overrun_o)
    );

endmodule

// File: tb/test_framed_rx.sv
module test_framed_rx;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0, fs_i = 1'b0, sd_i = 1'b0, rd_i = 1'b0;
    logic        cfg_clk_inv = 1'b0, cfg_fs_inv = 1'b0, cfg_dual = 1'b0, cfg_fs_ignore = 1'b0;
    logic [2:0]  cfg_len1 = 3'd0, cfg_len2 = 3'd0;
    logic [6:0]  cfg_cnt1 = 7'd0, cfg_cnt2 = 7'd0;
    logic [1:0]  cfg_delay = 2'd0, cfg_just = 2'd0;
    logic [31:0] word_o;
    logic        valid_o, overrun_o;

    framed_rx #(.CNT_W(7)) i_framed_rx (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .fs_i(fs_i), .sd_i(sd_i),
        .cfg_clk_inv(cfg_clk_inv), .cfg_fs_inv(cfg_fs_inv), .cfg_dual(cfg_dual),
        .cfg_len1(cfg_len1), .cfg_len2(cfg_len2), .cfg_cnt1(cfg_cnt1), .cfg_cnt2(cfg_cnt2),
        .cfg_delay(cfg_delay), .cfg_fs_ignore(cfg_fs_ignore), .cfg_just(cfg_just),
        .rd_i(rd_i), .word_o(word_o), .valid_o(valid_o), .overrun_o(overrun_o)
    );

    int          checks = 0, errors = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_w;
    string       tag = "none";
    bit          prev_v = 1'b0;

    // behavioural reference: 0 idle, 1 delay, 2 phase one, 3 phase two
    int          m_state = 0, m_d = 0, m_bits = 0, m_elems = 0;
    logic [31:0] m_acc = '0;
    bit          m_fsprev = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int width_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 12;
            3'd2: return 16;
            3'd3: return 20;
            3'd4: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] shape(input logic [31:0] acc, input int w);
        logic [63:0] v, mask;
        v    = {32'd0, acc};
        mask = (64'd1 << w) - 64'd1;
        if (cfg_just[1]) return 32'(v << (32 - w));
        if (cfg_just == 2'd1 && v[w-1]) return 32'(v | ~mask);
        return 32'(v & mask);
    endfunction

    task automatic model_rise(input bit d);
        int w, n;
        if (m_state == 1) begin
            if (m_d == 1) m_state = 2;
            else m_d--;
        end else if (m_state >= 2) begin
            w = width_of(m_state == 3 ? cfg_len2 : cfg_len1);
            n = 1 + int'(m_state == 3 ? cfg_cnt2 : cfg_cnt1);
            m_acc = {m_acc[30:0], d};
            m_bits++;
            if (m_bits == w) begin
                exp_q.push_back(shape(m_acc, w));
                m_bits = 0;
                m_acc  = '0;
                m_elems++;
                if (m_elems == n) begin
                    m_elems = 0;
                    m_state = (m_state == 2 && cfg_dual) ? 3 : 0;
                end
            end
        end
    endtask

    task automatic model_fall(input bit f);
        int dl;
        if (f && !m_fsprev && (m_state == 0 || !cfg_fs_ignore)) begin
            dl      = (cfg_delay == 2'd3) ? 2 : int'(cfg_delay);
            m_state = (dl == 0) ? 2 : 1;
            m_d     = dl;
            m_bits  = 0;
            m_elems = 0;
            m_acc   = '0;
        end
        m_fsprev = f;
    endtask

    // one bit slot: data taken at the internal rise, frame sync at the internal fall
    task automatic slot(input bit fsv, input bit dv);
        fs_i = fsv ^ cfg_fs_inv;
        sd_i = dv;
        repeat (2) @(negedge clk);
        sclk_i = ~cfg_clk_inv;
        model_rise(dv);
        repeat (4) @(negedge clk);
        sclk_i = cfg_clk_inv;
        model_fall(fsv);
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input int nbits);
        slot(1'b1, 1'($urandom));
        repeat (nbits) slot(1'b0, 1'($urandom));
    endtask

    task automatic setup(input bit ci, input bit fi, input bit du,
                         input logic [2:0] l1, input logic [2:0] l2,
                         input logic [6:0] c1, input logic [6:0] c2,
                         input logic [1:0] dl, input bit ign,
                         input logic [1:0] js, input bit rdv);
        rst_n = 1'b0;
        cfg_clk_inv = ci; cfg_fs_inv = fi; cfg_dual = du;
        cfg_len1 = l1; cfg_len2 = l2; cfg_cnt1 = c1; cfg_cnt2 = c2;
        cfg_delay = dl; cfg_fs_ignore = ign; cfg_just = js; rd_i = rdv;
        sclk_i = ci; fs_i = fi; sd_i = 1'b0;
        repeat (3) @(negedge clk);
        m_state = 0; m_d = 0; m_bits = 0; m_elems = 0; m_acc = '0; m_fsprev = 1'b0;
        exp_q.delete();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (24) @(negedge clk);
        check(exp_q.size() == 0, req, 32'(exp_q.size()), 32'd0);
    endtask

    // compared on every clock: each strobe against the model's queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                check(!prev_v, "R11 strobe longer than one cycle", 32'(prev_v), 32'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 word delivered with none expected", word_o, 32'd0);
                end else begin
                    exp_w = exp_q.pop_front();
                    check(word_o == exp_w, tag, word_o, exp_w);
                end
            end
            prev_v = valid_o;
        end else begin
            prev_v = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R13 reset state
        setup(0, 0, 0, 3'd2, 3'd0, 7'd2, 7'd0, 2'd1, 0, 2'd0, 1);
        check(word_o == 0 && !valid_o && !overrun_o, "R13 reset state",
              {word_o[29:0], valid_o, overrun_o}, 32'd0);

        // R4 R5 R7 R10: single phase, three 16-bit words, delay 1, zero fill
        tag = "R4 R7 R10 single-phase 16-bit word";
        frame(49 + 2);
        drain("R5 three elements of phase one");
        // R12: read held high so every completion meets a read
        check(!overrun_o, "R12 read in completion cycle", 32'(overrun_o), 32'd0);

        // R1 R2 R6 R10: inverted clock and sync, dual phase, sign extension, delay 0
        setup(1, 1, 1, 3'd0, 3'd4, 7'd1, 7'd0, 2'd0, 0, 2'd1, 1);
        tag = "R1 R2 R6 R10 dual-phase sign-extended word";
        frame(40 + 2);
        frame(40 + 2);
        drain("R6 two frames of two phases");

        // R6 R7 R10: 12-bit then two 20-bit, delay 2, left justified
        setup(0, 0, 1, 3'd1, 3'd3, 7'd0, 7'd1, 2'd2, 0, 2'd2, 1);
        tag = "R6 R7 R10 left-justified word";
        frame(52 + 2 + 2);
        drain("R7 delay two frame");

        // R8: restart drops the partial 32-bit element
        setup(0, 0, 0, 3'd5, 3'd0, 7'd1, 7'd0, 2'd0, 0, 2'd0, 1);
        tag = "R8 word after restart";
        slot(1'b1, 1'b0);
        repeat (20) slot(1'b0, 1'($urandom));
        slot(1'b1, 1'($urandom));
        repeat (66) slot(1'b0, 1'($urandom));
        drain("R8 restart frame");

        // R9: mid-frame sync ignored; R3: trailing bits while idle give nothing
        setup(0, 0, 0, 3'd5, 3'd0, 7'd1, 7'd0, 2'd0, 1, 2'd0, 1);
        tag = "R9 word with ignored sync";
        slot(1'b1, 1'b0);
        repeat (20) slot(1'b0, 1'($urandom));
        slot(1'b1, 1'($urandom));
        repeat (50) slot(1'b0, 1'($urandom));
        drain("R9 ignore frame");

        // R5 R7: 128 8-bit elements, delay code 3 acting as 2
        setup(0, 0, 0, 3'd0, 3'd0, 7'd127, 7'd0, 2'd3, 0, 2'd0, 1);
        tag = "R5 R7 128-element frame word";
        frame(1024 + 2 + 2);
        drain("R5 128 elements");

        // R12: no reads; first word no overrun, second sets it
        setup(0, 0, 0, 3'd0, 3'd0, 7'd0, 7'd0, 2'd0, 0, 2'd0, 0);
        tag = "R12 unread word";
        frame(10);
        drain("R12 first frame");
        check(!overrun_o, "R12 single unread word", 32'(overrun_o), 32'd0);
        frame(10);
        drain("R12 second frame");
        check(overrun_o, "R12 overrun on unread word", 32'(overrun_o), 32'd1);
        repeat (20) @(negedge clk);
        check(overrun_o, "R12 overrun sticky", 32'(overrun_o), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule